// File: doc/BRIEF.md
# Time-of-Day Clock, Alarm Comparator and Process Timer

This block keeps three independent 64-bit timing registers. The first is a time-of-day counter that moves forward by one microsecond on every pulse of a 1 MHz tick enable. The microsecond unit sits at bit 12, counting from the least significant bit, so the twelve bits below it give sub-microsecond resolution. At that weight the whole 64-bit range lasts 2^52 microseconds, which is about 143 years.

The second register is an alarm value. The block raises an alarm request while the time of day, read as an unsigned number, is strictly greater than the alarm value. The third register is a process timer. It counts down at the same weight, but only on ticks that arrive while the `cpu_running` input is high. It raises a request while its value is negative.

Each register has a load strobe with a 64-bit load value. Each register also has a read port that shows the whole registered value, with all 64 bits taken from the same clock edge. Masking and delivery of the two requests are handled elsewhere.

Top module: `tod_timer_unit`

## Requirements
- R1: While `rst_n` is low, all three registers are zero and both request flags are low.
- R2: On a cycle where `tick_us` is high and `tod_set` is low, the time of day grows by 2^12 (bit 12 counted from the LSB), wrapping modulo 2^64. Its low 12 bits are not changed by ticks.
- R3: On a cycle where both `tick_us` and `tod_set` are low, the time of day keeps its value.
- R4: When `tod_set` is high, the time of day equals `tod_set_val` after the next edge. This load wins over a tick in the same cycle.
- R5: When `cmp_load` is high, the alarm value equals `cmp_load_val` after the next edge. Otherwise the alarm value never changes.
- R6: `cmp_pending` is high exactly while the time of day is strictly greater than the alarm value, both compared as unsigned. Equal values give no request. Reloading either register so that the condition fails clears the flag.
- R7: The process timer drops by 2^12, modulo 2^64, on a cycle where `tick_us` and `cpu_running` are both high. On any other cycle without a load it holds its value.
- R8: When `cpt_load` is high, the process timer equals `cpt_load_val` after the next edge. This load wins over a decrement in the same cycle.
- R9: `cpt_pending` is high exactly while bit 63 of the process timer is one, that is, while the timer is negative in two's complement.
- R10: The read ports `tod_value`, `cmp_value` and `cpt_value` show the full registered values. This includes any sub-microsecond low bits that were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle pulse, once per microsecond |
| cpu_running | input | 1 | Enables the process timer to count down |
| tod_set | input | 1 | Load strobe for the time of day |
| tod_set_val | input | 64 | New time-of-day value |
| tod_value | output | 64 | Current time of day |
| cmp_load | input | 1 | Load strobe for the alarm value |
| cmp_load_val | input | 64 | New alarm value |
| cmp_value | output | 64 | Current alarm value |
| cpt_load | input | 1 | Load strobe for the process timer |
| cpt_load_val | input | 64 | New process-timer value |
| cpt_value | output | 64 | Current process-timer value |
| cmp_pending | output | 1 | Alarm request |
| cpt_pending | output | 1 | Process-timer request |

## Verification
The bench drives loads that arrive together with ticks. A design that gave the tick priority would show the loaded value plus or minus one microsecond.

The time of day is set just below 2^64 and then ticked across zero. A design that compared the registers as signed numbers, or that missed the wrap, would keep or raise the alarm flag wrongly there.

Equal time-of-day and alarm values are checked to give no request. This catches a design that compares with greater-or-equal instead of strictly greater.

The process timer is stepped from a small positive value into negative values, and it is also held with `cpu_running` low. A design that decremented on every tick, or that read the sign from the wrong bit, fails these checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int TMR_W    = 64;
  parameter int TICK_BIT = 12;

  function automatic logic [TMR_W-1:0] tod_advance(input logic [TMR_W-1:0] v);
    return v + (TMR_W'(1) << TICK_BIT);
  endfunction

  function automatic logic [TMR_W-1:0] cpt_retard(input logic [TMR_W-1:0] v);
    return v - (TMR_W'(1) << TICK_BIT);
  endfunction

  function automatic logic cmp_exceeds(input logic [TMR_W-1:0] tod,
                                       input logic [TMR_W-1:0] alarm);
    return tod > alarm;
  endfunction

  function automatic logic is_negative(input logic [TMR_W-1:0] v);
    return v[TMR_W-1];
  endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tmr_pkg::*;
#(
  parameter int W = TMR_W,
  parameter int TB = TICK_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         set,
  input  logic [W-1:0] set_val,
  output logic [W-1:0] tod_q
);
  localparam int LOW_W = TB;

  logic         adv_ev;
  logic [W-1:0] tod_nxt;

  assign adv_ev = tick && !set;

  always_comb begin
    tod_nxt = tod_q;
    if (set)
      tod_nxt = set_val;
    else if (tick)
      tod_nxt = W'(tod_advance(TMR_W'(tod_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tod_q <= '0;
    else        tod_q <= tod_nxt;
  end

  // R4: a set strobe wins over a tick in the same cycle.
  assert_tod_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> tod_q == $past(set_val));

  // R2: a tick leaves the low sub-microsecond bits as they were.
  assert_tod_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> tod_q[LOW_W-1:0] == $past(tod_q[LOW_W-1:0]));

  // R3: with no tick and no set, the value holds.
  assert_tod_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !set) |=> $stable(tod_q));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] tod_in,
  input  logic         tod_moved,
  output logic [W-1:0] alarm_q,
  output logic         pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    alarm_q <= '0;
    else if (load) alarm_q <= load_val;
  end

  assign pending = cmp_exceeds(TMR_W'(tod_in), TMR_W'(alarm_q));

  // R5: without a load, the alarm value never changes.
  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(alarm_q));

  // R6: the request can only rise after one of the two registers was updated.
  assert_cmp_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> ($past(tod_moved) || $past(load)));
endmodule

// File: rtl/cpu_interval_timer.sv
module cpu_interval_timer
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         running,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cpt_q,
  output logic         pending
);
  logic         dec_ev;
  logic [W-1:0] cpt_nxt;

  assign dec_ev = tick && running;

  always_comb begin
    cpt_nxt = cpt_q;
    if (load)
      cpt_nxt = load_val;
    else if (dec_ev)
      cpt_nxt = W'(cpt_retard(TMR_W'(cpt_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpt_q <= '0;
    else        cpt_q <= cpt_nxt;
  end

  assign pending = is_negative(TMR_W'(cpt_q));

  // R8: a load wins over a decrement in the same cycle.
  assert_cpt_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cpt_q == $past(load_val));

  // R7: the timer holds when the processor is not running and there is no load.
  assert_cpt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !running) |=> $stable(cpt_q));
endmodule

// File: rtl/tod_timer_unit.sv
module tod_timer_unit
  import tmr_pkg::*;
#(
  parameter int W  = TMR_W,
  parameter int TB = TICK_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_us,
  input  logic         cpu_running,
  input  logic         tod_set,
  input  logic [W-1:0] tod_set_val,
  output logic [W-1:0] tod_value,
  input  logic         cmp_load,
  input  logic [W-1:0] cmp_load_val,
  output logic [W-1:0] cmp_value,
  input  logic         cpt_load,
  input  logic [W-1:0] cpt_load_val,
  output logic [W-1:0] cpt_value,
  output logic         cmp_pending,
  output logic         cpt_pending
);
  logic tod_moved;

  assign tod_moved = tick_us || tod_set;

  tod_counter #(.W(W), .TB(TB)) u_tod (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .set(tod_set),
    .set_val(tod_set_val), .tod_q(tod_value)
  );

  alarm_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .load(cmp_load), .load_val(cmp_load_val),
    .tod_in(tod_value), .tod_moved(tod_moved),
    .alarm_q(cmp_value), .pending(cmp_pending)
  );

  cpu_interval_timer #(.W(W)) u_cpt (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .running(cpu_running),
    .load(cpt_load), .load_val(cpt_load_val),
    .cpt_q(cpt_value), .pending(cpt_pending)
  );

  // R1: both request flags are low during reset.
  always_comb begin
    if (!rst_n) begin
      assert_reset_flags_R1: assert (!cmp_pending && !cpt_pending);
    end
  end

  // R9: the timer request follows the sign of the timer value.
  assert_cpt_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpt_load && cpt_load_val[W-1]) |=> cpt_pending);
endmodule

// File: tb/tb_tod_timer_unit.sv
module tb_tod_timer_unit;
  localparam longint unsigned STEP = 64'd4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0, cpu_running = 1'b0;
  logic        tod_set = 1'b0, cmp_load = 1'b0, cpt_load = 1'b0;
  logic [63:0] tod_set_val = '0, cmp_load_val = '0, cpt_load_val = '0;
  logic [63:0] tod_value, cmp_value, cpt_value;
  logic        cmp_pending, cpt_pending;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  longint unsigned m_tod = 0, m_cmp = 0, m_cpt = 0;

  always #2 clk = ~clk;

  tod_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cpu_running(cpu_running),
    .tod_set(tod_set), .tod_set_val(tod_set_val), .tod_value(tod_value),
    .cmp_load(cmp_load), .cmp_load_val(cmp_load_val), .cmp_value(cmp_value),
    .cpt_load(cpt_load), .cpt_load_val(cpt_load_val), .cpt_value(cpt_value),
    .cmp_pending(cmp_pending), .cpt_pending(cpt_pending)
  );

  // Behavioural reference, updated on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tod = 0; m_cmp = 0; m_cpt = 0;
    end else begin
      if (tod_set) m_tod = tod_set_val;
      else if (tick_us) m_tod = m_tod + STEP;
      if (cmp_load) m_cmp = cmp_load_val;
      if (cpt_load) m_cpt = cpt_load_val;
      else if (tick_us && cpu_running) m_cpt = m_cpt - STEP;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2/R4", "tod_value", tod_value, m_tod);
    chk("R5", "cmp_value", cmp_value, m_cmp);
    chk("R7/R8", "cpt_value", cpt_value, m_cpt);
    chk("R6", "cmp_pending", {63'd0, cmp_pending}, {63'd0, m_tod > m_cmp});
    chk("R9", "cpt_pending", {63'd0, cpt_pending}, {63'd0, m_cpt[63]});
  endtask

  task automatic idle_inputs();
    tick_us = 0; tod_set = 0; cmp_load = 0; cpt_load = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    compare_all();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    longint unsigned lf;
    lf = 64'h9E37_79B9_7F4A_7C15;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "tod reset", tod_value, 64'd0);
    chk("R1", "cmp reset", cmp_value, 64'd0);
    chk("R1", "cpt reset", cpt_value, 64'd0);
    chk("R1", "flags reset", {62'd0, cmp_pending, cpt_pending}, 64'd0);
    rst_n = 1;
    cyc();

    // R2 ticks with the processor idle; R7 hold on the process timer
    tick_us = 1;
    repeat (5) cyc();
    chk("R2", "tod after 5 ticks", tod_value, 5 * STEP);
    chk("R7", "cpt idle", cpt_value, 64'd0);
    // R3 hold without tick
    tick_us = 0;
    repeat (3) cyc();
    chk("R3", "tod hold", tod_value, 5 * STEP);

    // R4 set together with tick; R10 low bits visible
    tick_us = 1; tod_set = 1; tod_set_val = 64'h0000_0001_0000_0ABC;
    cyc();
    chk("R4", "set wins over tick", tod_value, 64'h0000_0001_0000_0ABC);
    tod_set = 0;
    cyc();
    chk("R10", "low bits after tick", tod_value, 64'h0000_0001_0000_1ABC);

    // R6 alarm at equal then exceeded
    tick_us = 0; cmp_load = 1; cmp_load_val = 64'h0000_0001_0000_2ABC;
    cyc();
    cmp_load = 0;
    chk("R5", "alarm loaded", cmp_value, 64'h0000_0001_0000_2ABC);
    tick_us = 1; cyc(); tick_us = 0;
    chk("R6", "equal gives no request", {63'd0, cmp_pending}, 64'd0);
    tick_us = 1; cyc(); tick_us = 0;
    chk("R6", "greater gives request", {63'd0, cmp_pending}, 64'd1);
    cmp_load = 1; cmp_load_val = 64'hFFFF_0000_0000_0000; cyc(); cmp_load = 0;
    chk("R6", "alarm reload clears", {63'd0, cmp_pending}, 64'd0);

    // R2 wrap past 2^64, alarm drops as an unsigned comparison
    cmp_load = 1; cmp_load_val = 64'd100; tod_set = 1;
    tod_set_val = 64'hFFFF_FFFF_FFFF_F000;
    cyc();
    cmp_load = 0; tod_set = 0;
    chk("R6", "near top pending", {63'd0, cmp_pending}, 64'd1);
    tick_us = 1; cyc(); tick_us = 0;
    chk("R2", "wrap to zero", tod_value, 64'd0);
    chk("R6", "after wrap no request", {63'd0, cmp_pending}, 64'd0);

    // R7/R9 process timer into negative
    cpt_load = 1; cpt_load_val = 2 * STEP; cyc(); cpt_load = 0;
    cpu_running = 1; tick_us = 1;
    cyc(); cyc();
    chk("R7", "timer at zero", cpt_value, 64'd0);
    chk("R9", "zero not negative", {63'd0, cpt_pending}, 64'd0);
    cyc();
    chk("R9", "negative request", {63'd0, cpt_pending}, 64'd1);
    cpu_running = 0;
    cyc();
    chk("R7", "no decrement when not running", cpt_value, 64'd0 - STEP);
    // R8 load wins over decrement
    cpu_running = 1; cpt_load = 1; cpt_load_val = 64'h0000_0000_0001_0123;
    cyc();
    chk("R8", "load wins", cpt_value, 64'h0000_0000_0001_0123);
    chk("R10", "cpt low bits", cpt_value[11:0], 64'h123);
    idle_inputs(); cpu_running = 0;

    // Pseudo-random traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
      tick_us     = lf[0] | lf[1];
      cpu_running = lf[2] | lf[3];
      tod_set     = (lf[11:6] == 6'd0);
      cmp_load    = (lf[17:12] == 6'd1);
      cpt_load    = (lf[23:18] == 6'd2);
      tod_set_val  = {lf[63:40], 40'd0} ^ {52'd0, lf[11:0]};
      cmp_load_val = m_tod + {lf[30:24], 12'd0} - 64'd40000;
      cpt_load_val = {51'd0, lf[44:32]};
      cyc();
    end
    idle_inputs();
    cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule